// File: doc/BRIEF.md
# Masked Field Deposit Unit

This unit carries out a bit-masked read-modify-write on one word of data memory. Its operands are the top words of a register stack. A mask word picks which bits of the target word are replaced from a data word. All other bits keep their old value. The new word is written back, and a condition code is set from it.

There are two command forms. The short form takes a 16-bit word address and can target either the current data segment or the system data segment. The extended form takes a 32-bit byte address built from two stack words. That address must be even, and it targets the extended address space.

At the end of every command the unit reports how many stack words the stack logic must pop. Commands enter through a valid/ready handshake, and the operands are sampled on the accepting edge. While a command is in flight, `cmd_ready` stays low. A requester may hold `cmd_valid` and its operands during that time without effect, and its command is taken once `cmd_ready` rises again. The memory port is a plain synchronous port: read data arrives one cycle after the read strobe.

Top module: `fdep_unit`

## Requirements
- R1: After reset, `cmd_ready` is 1, and `done`, `align_err`, `mem_rd_en` and `mem_wr_en` are 0. `cc` is 2'b00 and `pop_cnt` is 0.
- R2: The word written back is (old & ~mask) | (data & mask). A mask bit of 1 takes the data bit, and a mask of zero writes the old word back unchanged.
- R3: When `cmd_op[1]` is 0 (short form), the fields come from these stack words:
  - `stk_a` is the word address, zero-extended.
  - `stk_b` is the mask.
  - `stk_c` is the data.
  - `cmd_op[0]` picks the segment: 0 gives `mem_seg` 2'b00 (current data), and 1 gives `mem_seg` 2'b01 (system data).
- R4: When `cmd_op[1]` is 1 (extended form), the fields come from these stack words:
  - `stk_d` is the data.
  - `stk_c` is the mask.
  - {`stk_b`,`stk_a`} is a 32-bit byte address, and `mem_addr` is that address shifted right by one.
  - `mem_seg` is 2'b10.
- R5: Cycles are counted from the accepting edge. `mem_rd_en` is high for exactly cycle 1, `mem_wr_en` for exactly cycle 3, and `done` for exactly cycle 4. The read and write strobes are never high together.
- R6: When `done` rises, `cc` shows the written word: 2'b00 if it is zero, 2'b10 if bit 15 is set (negative), and 2'b01 otherwise. `cc` does not change while `done` is low.
- R7: `pop_cnt` is 3 for the short form and 4 for the extended form, and it is valid only while `done` is high. It is 0 at all other times.
- R8: An extended command with an odd byte address makes no read and no write. It raises `done` with `align_err`=1 in the cycle after acceptance, keeps `cc` unchanged and reports `pop_cnt`=4. `align_err` is 0 on every other `done`.
- R9: `cmd_ready` is low from the cycle after acceptance through the `done` cycle, and returns high in the cycle after `done`. A command held valid during that time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_op | input | 2 | Bit 1: extended form; bit 0: system segment (short form only) |
| stk_a | input | 16 | Stack top word |
| stk_b | input | 16 | Second stack word |
| stk_c | input | 16 | Third stack word |
| stk_d | input | 16 | Fourth stack word |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_seg | output | 2 | Segment: 00 data, 01 system, 10 extended |
| mem_addr | output | 31 | Word address |
| mem_wdata | output | 16 | Merged word to write |
| mem_rdata | input | 16 | Read data, valid one cycle after the read strobe |
| done | output | 1 | One-cycle completion pulse |
| cc | output | 2 | Condition code of the last merged word |
| align_err | output | 1 | Odd extended address, with `done` |
| pop_cnt | output | 3 | Stack words to pop, with `done` |

## Verification
Cycle 0 is the accepting edge. The read strobe is due in cycle 1, the write strobe in cycle 3, and `done` together with `cc` and `pop_cnt` in cycle 4. On a misaligned command, `done` and `align_err` are due in cycle 1 instead. The bench records the edge at which each strobe is seen and compares its distance from the accepting edge with these numbers. It samples `done`, `cc`, `pop_cnt` and `cmd_ready` at falling edges, counting from acceptance. Memory contents and access counts are compared one cycle after `done`, once the bench memory has taken the write.

// File: rtl/fdep_pkg.sv
`timescale 1ns/1ps
package fdep_pkg;
  typedef enum logic [1:0] {SEG_DATA = 2'b00, SEG_SYS = 2'b01, SEG_EXT = 2'b10} seg_e;
  typedef enum logic [1:0] {CC_ZERO = 2'b00, CC_POS = 2'b01, CC_NEG = 2'b10} cc_e;
  typedef enum logic [2:0] {ST_IDLE = 3'd0, ST_RD = 3'd1, ST_MRG = 3'd2,
                            ST_WR = 3'd3, ST_FIN = 3'd4} st_e;
  localparam int unsigned POPS_SHORT = 3;
  localparam int unsigned POPS_EXT   = 4;
endpackage

// File: rtl/fdep_decode.sv
`timescale 1ns/1ps
// Splits the stack words into address, segment, mask and data by command form.
module fdep_decode
  import fdep_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 3,
  localparam int BW  = 2 * DW,
  localparam int MAW = BW - 1
) (
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] c_i,
  input  logic [DW-1:0] d_i,
  output logic [MAW-1:0] addr_o,
  output logic [1:0]    seg_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] data_o,
  output logic [PW-1:0] pops_o,
  output logic          misalign_o
);
  logic [BW-1:0] byte_addr;
  assign byte_addr = {b_i, a_i};

  always_comb begin
    if (op_i[1]) begin
      // extended form: byte address in two words, mask and data deeper down
      addr_o     = byte_addr[BW-1:1];
      seg_o      = SEG_EXT;
      mask_o     = c_i;
      data_o     = d_i;
      pops_o     = PW'(POPS_EXT);
      misalign_o = byte_addr[0];
    end else begin
      addr_o     = MAW'(a_i);
      seg_o      = op_i[0] ? SEG_SYS : SEG_DATA;
      mask_o     = b_i;
      data_o     = c_i;
      pops_o     = PW'(POPS_SHORT);
      misalign_o = 1'b0;
    end
  end
endmodule

// File: rtl/fdep_merge.sv
`timescale 1ns/1ps
// Bitwise field merge and sign/zero classification of the result.
module fdep_merge
  import fdep_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] merged_o,
  output logic [1:0]    cc_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign merged_o[i] = mask_i[i] ? data_i[i] : old_i[i];
  end

  always_comb begin
    if (merged_o == '0)        cc_o = CC_ZERO;
    else if (merged_o[DW-1])   cc_o = CC_NEG;
    else                       cc_o = CC_POS;
  end
endmodule

// File: rtl/fdep_ctrl.sv
`timescale 1ns/1ps
// Sequencer: read, merge, write, finish; misaligned commands skip to finish.
module fdep_ctrl
  import fdep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid_i,
  input  logic misalign_i,
  output logic cmd_ready_o,
  output logic accept_o,
  output logic rd_o,
  output logic cap_o,
  output logic wr_o,
  output logic done_o
);
  st_e st_q, st_d;

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign accept_o    = cmd_valid_i && cmd_ready_o;
  assign rd_o        = (st_q == ST_RD);
  assign cap_o       = (st_q == ST_MRG);
  assign wr_o        = (st_q == ST_WR);
  assign done_o      = (st_q == ST_FIN);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept_o) st_d = misalign_i ? ST_FIN : ST_RD;
      ST_RD:   st_d = ST_MRG;
      ST_MRG:  st_d = ST_WR;
      ST_WR:   st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd_o && wr_o)); // R5
  AST_WR_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n) wr_o |=> done_o); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R5
  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n) accept_o |=> !cmd_ready_o); // R9
  AST_MIS_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && misalign_i) |=> (done_o && !rd_o)); // R8
endmodule

// File: rtl/fdep_unit.sv
`timescale 1ns/1ps
// Masked field deposit: stack operands in, read-modify-write on memory.
module fdep_unit
  import fdep_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 3,
  localparam int MAW = 2 * DW - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [1:0]     cmd_op,
  input  logic [DW-1:0]  stk_a,
  input  logic [DW-1:0]  stk_b,
  input  logic [DW-1:0]  stk_c,
  input  logic [DW-1:0]  stk_d,
  output logic           mem_rd_en,
  output logic           mem_wr_en,
  output logic [1:0]     mem_seg,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           done,
  output logic [1:0]     cc,
  output logic           align_err,
  output logic [PW-1:0]  pop_cnt
);
  logic [MAW-1:0] addr_d, addr_q;
  logic [1:0]     seg_d, seg_q;
  logic [DW-1:0]  mask_d, mask_q, data_d, data_q;
  logic [PW-1:0]  pops_d, pops_q;
  logic           mis_d;
  logic           accept, cap, wr;
  logic [DW-1:0]  merged_w, merged_q;
  logic [1:0]     mcc_w, mcc_q;

  fdep_decode #(.DW(DW), .PW(PW)) u_dec (
    .op_i(cmd_op), .a_i(stk_a), .b_i(stk_b), .c_i(stk_c), .d_i(stk_d),
    .addr_o(addr_d), .seg_o(seg_d), .mask_o(mask_d), .data_o(data_d),
    .pops_o(pops_d), .misalign_o(mis_d)
  );

  fdep_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .misalign_i(mis_d),
    .cmd_ready_o(cmd_ready), .accept_o(accept), .rd_o(mem_rd_en),
    .cap_o(cap), .wr_o(wr), .done_o(done)
  );

  fdep_merge #(.DW(DW)) u_mrg (
    .old_i(mem_rdata), .mask_i(mask_q), .data_i(data_q),
    .merged_o(merged_w), .cc_o(mcc_w)
  );

  assign mem_wr_en = wr;
  assign mem_addr  = addr_q;
  assign mem_seg   = seg_q;
  assign mem_wdata = merged_q;

  // operand capture on acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0; seg_q <= SEG_DATA; mask_q <= '0; data_q <= '0; pops_q <= '0;
    end else if (accept) begin
      addr_q <= addr_d; seg_q <= seg_d; mask_q <= mask_d;
      data_q <= data_d; pops_q <= pops_d;
    end
  end

  // merge result registered the cycle read data is present
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      merged_q <= '0; mcc_q <= CC_ZERO;
    end else if (cap) begin
      merged_q <= merged_w; mcc_q <= mcc_w;
    end
  end

  // completion status, aligned with done
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc <= CC_ZERO; align_err <= 1'b0; pop_cnt <= '0;
    end else if (wr) begin
      cc <= mcc_q; align_err <= 1'b0; pop_cnt <= pops_q;
    end else if (accept && mis_d) begin
      align_err <= 1'b1; pop_cnt <= pops_d;
    end else begin
      align_err <= 1'b0; pop_cnt <= '0;
    end
  end

  AST_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (((mem_wdata ^ data_q) & mask_q) == '0)); // R2
  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(cc)); // R6
  AST_POP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pop_cnt == PW'(POPS_SHORT) || pop_cnt == PW'(POPS_EXT))); // R7
  AST_POP_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !done |-> pop_cnt == '0); // R7
  AST_ALIGN_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) align_err |-> done); // R8
endmodule

// File: tb/fdep_unit_tb_top.sv
`timescale 1ns/1ps
module fdep_unit_tb_top;
  localparam int DW = 16;
  localparam int MAW = 2 * DW - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [DW-1:0] stk_a = '0, stk_b = '0, stk_c = '0, stk_d = '0;
  logic mem_rd_en, mem_wr_en;
  logic [1:0] mem_seg;
  logic [MAW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic done, align_err;
  logic [1:0] cc;
  logic [2:0] pop_cnt;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fdep_unit #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .stk_a(stk_a), .stk_b(stk_b), .stk_c(stk_c), .stk_d(stk_d),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_seg(mem_seg),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .cc(cc), .align_err(align_err), .pop_cnt(pop_cnt)
  );

  // memory model: three segments of 64 words, one-cycle read latency
  logic [DW-1:0] mem [0:2][0:63];
  int cyc = 0, acc_cyc = 0, rd_cyc = 0, wr_cyc = 0;
  int rd_cnt = 0, wr_cnt = 0, acc_cnt = 0;
  logic [MAW-1:0] wr_addr = '0;
  logic [1:0] wr_seg = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cmd_valid && cmd_ready) begin acc_cyc <= cyc; acc_cnt <= acc_cnt + 1; end
    if (mem_rd_en) begin
      rd_cyc <= cyc; rd_cnt <= rd_cnt + 1;
      if (mem_seg != 2'b11) mem_rdata <= mem[mem_seg][mem_addr[5:0]];
    end
    if (mem_wr_en) begin
      wr_cyc <= cyc; wr_cnt <= wr_cnt + 1; wr_addr <= mem_addr; wr_seg <= mem_seg;
      if (mem_seg != 2'b11) mem[mem_seg][mem_addr[5:0]] <= mem_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one command; lat = falling edges from acceptance to done
  task automatic run(input logic [1:0] op, input logic [15:0] a, b, c, d,
                     output int lat, output int busy_rdy, output logic [1:0] cc_s,
                     output logic al_s, output logic [2:0] pop_s);
    @(negedge clk);
    cmd_op = op; stk_a = a; stk_b = b; stk_c = c; stk_d = d; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lat = 1; busy_rdy = 0;
    // valid stays high while busy: must not be taken (R9)
    while (!done && lat < 20) begin
      if (cmd_ready) busy_rdy++;
      @(negedge clk);
      lat++;
    end
    if (cmd_ready) busy_rdy++;
    cc_s = cc; al_s = align_err; pop_s = pop_cnt;
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R9 ready back after done", 32'(cmd_ready), 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 ready", 32'(cmd_ready), 32'd1);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 rd/wr", {30'd0, mem_rd_en, mem_wr_en}, 32'd0);
    chk("R1 cc", 32'(cc), 32'd0);
    chk("R1 align/pop", {28'd0, align_err, pop_cnt}, 32'd0);
  endtask

  task automatic t_short_data();
    int lat, br; logic [1:0] c; logic al; logic [2:0] p; int a0;
    mem[0][5] = 16'hA5A5; mem[1][5] = 16'h3C3C;
    a0 = acc_cnt;
    run(2'b00, 16'd5, 16'h0FF0, 16'h1234, 16'hDEAD, lat, br, c, al, p);
    chk("R2 merged word", 32'(mem[0][5]), 32'h0000A235);
    chk("R3 data segment", 32'(wr_seg), 32'd0);
    chk("R3 short address", 32'(wr_addr), 32'd5);
    chk("R3 other segment untouched", 32'(mem[1][5]), 32'h00003C3C);
    chk("R5 read one cycle after accept", 32'(rd_cyc - acc_cyc), 32'd1);
    chk("R5 write three cycles after accept", 32'(wr_cyc - acc_cyc), 32'd3);
    chk("R5 done four cycles after accept", 32'(lat), 32'd4);
    chk("R6 negative cc", 32'(c), 32'd2);
    chk("R7 short pops", 32'(p), 32'd3);
    chk("R8 no align err", 32'(al), 32'd0);
    chk("R9 ready low while busy", 32'(br), 32'd0);
    chk("R9 single accept", 32'(acc_cnt - a0), 32'd1);
  endtask

  task automatic t_short_sys();
    int lat, br; logic [1:0] c; logic al; logic [2:0] p;
    mem[1][9] = 16'h00F0; mem[0][9] = 16'h1111;
    run(2'b01, 16'd9, 16'h000F, 16'hFFFF, 16'h0000, lat, br, c, al, p);
    chk("R3 system word merged", 32'(mem[1][9]), 32'h000000FF);
    chk("R3 system segment", 32'(wr_seg), 32'd1);
    chk("R3 data segment untouched", 32'(mem[0][9]), 32'h00001111);
    chk("R6 positive cc", 32'(c), 32'd1);
    chk("R7 short pops sys", 32'(p), 32'd3);
  endtask

  task automatic t_zero_and_nomask();
    int lat, br; logic [1:0] c; logic al; logic [2:0] p;
    mem[0][3] = 16'h8001;
    run(2'b00, 16'd3, 16'hFFFF, 16'h0000, 16'h0, lat, br, c, al, p);
    chk("R2 full mask clears", 32'(mem[0][3]), 32'd0);
    chk("R6 zero cc", 32'(c), 32'd0);
    mem[0][4] = 16'h7E00;
    run(2'b00, 16'd4, 16'h0000, 16'hFFFF, 16'h0, lat, br, c, al, p);
    chk("R2 empty mask keeps word", 32'(mem[0][4]), 32'h00007E00);
    chk("R6 positive cc unchanged word", 32'(c), 32'd1);
  endtask

  task automatic t_extended();
    int lat, br; logic [1:0] c; logic al; logic [2:0] p;
    mem[2][10] = 16'h5555;
    run(2'b10, 16'h0014, 16'h0001, 16'hFF00, 16'h0F0F, lat, br, c, al, p);
    chk("R4 extended merged", 32'(mem[2][10]), 32'h00000F55);
    chk("R4 word address", 32'(wr_addr), 32'h0000800A);
    chk("R4 extended segment", 32'(wr_seg), 32'd2);
    chk("R5 extended done latency", 32'(lat), 32'd4);
    chk("R7 extended pops", 32'(p), 32'd4);
    chk("R8 aligned no error", 32'(al), 32'd0);
    chk("R6 extended positive cc", 32'(c), 32'd1);
  endtask

  task automatic t_misalign();
    int lat, br; logic [1:0] c; logic al; logic [2:0] p; int r0, w0;
    logic [1:0] cc0;
    cc0 = cc; r0 = rd_cnt; w0 = wr_cnt;
    run(2'b10, 16'h0015, 16'h0000, 16'hFFFF, 16'h0000, lat, br, c, al, p);
    chk("R8 done next cycle", 32'(lat), 32'd1);
    chk("R8 align err", 32'(al), 32'd1);
    chk("R8 no read", 32'(rd_cnt - r0), 32'd0);
    chk("R8 no write", 32'(wr_cnt - w0), 32'd0);
    chk("R8 cc unchanged", 32'(c), 32'(cc0));
    chk("R8 pops four", 32'(p), 32'd4);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 3; s++)
      for (int w = 0; w < 64; w++) mem[s][w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short_data();
    t_short_sys();
    t_zero_and_nomask();
    t_extended();
    t_misalign();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule